// File: doc/BRIEF.md
# Wait-State Memory Access Controller

This block sits between an 8-bit processor core and its memories. For every core access it decides, within the same cycle, whether the target is the on-chip register RAM, one of the two internal ROM halves, or the external parallel bus. It then drives the matching select line or external strobe. For slow targets it holds the core's ready input low for a programmed number of extra clocks.

Code space and data space stay apart on the external bus through four active-low strobes: code read, code write, data read and data write. Data-space addresses below the register-space limit (448 by default) reach the register RAM and never wait. Code reads to an internal ROM half that is enabled by its active-low pin are served on chip. When a half is disabled, its code reads go to the external bus. The address bit 15 picks the half.

The sequencer has two states. `ST_IDLE` accepts a request: a zero-wait access completes there (transition *finish-now*), otherwise the sequencer moves to `ST_STRETCH` (transition *begin-stretch*). `ST_STRETCH` counts down the remaining wait clocks. It returns to `ST_IDLE` when ready is given (transition *complete*) or when the core drops its request (transition *abandon*).

Top module: `wait_bus_ctrl`

## Requirements
- R1: While no request is active, all four external strobes are high, the write-drive enable is low and core_ready is low.
- R2: A data-space access with address below REG_LIMIT (448) completes in one clock: core_ready is high in the request's first cycle, reg_sel is high and no external strobe fires; reads return reg_rdata.
- R3: A code read whose half is enabled (address bit 15 = 0 uses rom_lo_en_n, = 1 uses rom_hi_en_n, enable when low) sets rom_sel, fires no strobe, returns rom_rdata and lasts code_waits+1 clocks, or 1 clock when rom_nowait is high.
- R4: A code read to a disabled ROM half goes to the external bus with the code-read strobe low and returns ext_din.
- R5: An external code-space access lasts code_waits+1 clocks (core_ready low for code_waits clocks, then high).
- R6: An external data-space access lasts max(data_waits, code_waits)+1 clocks, so the longest stall is 7 extra clocks.
- R7: At most one strobe is low at a time; code writes always use the code-write strobe and data writes outside register space use the data-write strobe.
- R8: ext_oe is high only while a write strobe is low, and then ext_dout equals core_wdata.
- R9: During an external access ext_addr equals core_addr.
- R10: A data read at or above REG_LIMIT goes external with the data-read strobe low and returns ext_din.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_req | input | 1 | Access request, held with address and controls until ready |
| core_we | input | 1 | 1 = write, 0 = read |
| core_code | input | 1 | 1 = code space, 0 = data space |
| core_addr | input | 16 | Access address |
| core_wdata | input | 8 | Write data |
| core_rdata | output | 8 | Read data returned to the core |
| core_ready | output | 1 | High in the final cycle of an access |
| code_waits | input | 3 | Wait states for code-space accesses |
| data_waits | input | 3 | Requested wait states for external data accesses |
| rom_nowait | input | 1 | Internal ROM reads skip wait states |
| rom_lo_en_n | input | 1 | Enables lower ROM half when low |
| rom_hi_en_n | input | 1 | Enables upper ROM half when low |
| reg_sel | output | 1 | Register RAM selected |
| reg_rdata | input | 8 | Register RAM read data |
| rom_sel | output | 1 | Internal ROM selected |
| rom_rdata | input | 8 | Internal ROM read data |
| ext_addr | output | 16 | External address bus |
| ext_dout | output | 8 | External data driven out |
| ext_din | input | 8 | External data read in |
| ext_oe | output | 1 | External data bus drive enable |
| ext_code_rd_n | output | 1 | Code read strobe, active low |
| ext_code_wr_n | output | 1 | Code write strobe, active low |
| ext_data_rd_n | output | 1 | Data read strobe, active low |
| ext_data_wr_n | output | 1 | Data write strobe, active low |

## Verification
A wrong wait count or a stuck `ST_STRETCH` state shows at the port as a core_ready that rises one or more clocks early or late. The scoreboard catches this at the end of that same access. A decode fault shows within the request's first cycle as the wrong strobe, a missing select or the wrong read-data source. A bad drive enable shows in the cycle it occurs, because ext_oe is compared against the expected write target on every clock of an access.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
    typedef enum logic [1:0] {
        TGT_REG = 2'd0,
        TGT_ROM = 2'd1,
        TGT_EXT = 2'd2
    } target_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_STRETCH = 1'b1
    } seq_state_e;
endpackage

// File: rtl/wbc_decode.sv
module wbc_decode
    import wbc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int WAIT_W    = 3,
    parameter int REG_LIMIT = 448
) (
    input  logic              code,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic              lo_en_n,
    input  logic              hi_en_n,
    input  logic              rom_nowait,
    input  logic [WAIT_W-1:0] code_waits,
    input  logic [WAIT_W-1:0] data_waits,
    output target_e           target,
    output logic [WAIT_W-1:0] waits
);
    localparam int HALF_BIT = ADDR_W - 1;

    logic              half_on;
    logic [WAIT_W-1:0] data_eff;

    always_comb begin
        half_on  = addr[HALF_BIT] ? !hi_en_n : !lo_en_n;
        data_eff = (data_waits > code_waits) ? data_waits : code_waits;
        if (!code && (32'(addr) < REG_LIMIT))
            target = TGT_REG;
        else if (code && !we && half_on)
            target = TGT_ROM;
        else
            target = TGT_EXT;
        unique case (target)
            TGT_REG: waits = '0;
            TGT_ROM: waits = rom_nowait ? '0 : code_waits;
            TGT_EXT: waits = code ? code_waits : data_eff;
            default: waits = '0;
        endcase
    end
endmodule

// File: rtl/wbc_seq.sv
module wbc_seq
    import wbc_pkg::*;
#(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [WAIT_W-1:0] waits,
    output logic              ready
);
    seq_state_e        state, state_nx;
    logic [WAIT_W-1:0] cnt, cnt_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        ready    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req) begin
                    if (waits == '0) begin
                        ready = 1'b1;
                    end else begin
                        state_nx = ST_STRETCH;
                        cnt_nx   = waits - 1'b1;
                    end
                end
            end
            ST_STRETCH: begin
                if (!req) begin
                    state_nx = ST_IDLE;
                end else if (cnt == '0) begin
                    ready    = 1'b1;
                    state_nx = ST_IDLE;
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    p_ready_has_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> req);
    p_done_to_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> (state == ST_IDLE));
endmodule

// File: rtl/wbc_port.sv
module wbc_port
    import wbc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              req,
    input  logic              we,
    input  logic              code,
    input  target_e           target,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] ext_din,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic [DATA_W-1:0] rdata,
    output logic              reg_sel,
    output logic              rom_sel,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_dout,
    output logic              ext_oe,
    output logic              code_rd_n,
    output logic              code_wr_n,
    output logic              data_rd_n,
    output logic              data_wr_n
);
    logic go_ext;

    always_comb begin
        go_ext    = req && (target == TGT_EXT);
        reg_sel   = req && (target == TGT_REG);
        rom_sel   = req && (target == TGT_ROM);
        code_rd_n = !(go_ext && code && !we);
        code_wr_n = !(go_ext && code && we);
        data_rd_n = !(go_ext && !code && !we);
        data_wr_n = !(go_ext && !code && we);
        ext_oe    = go_ext && we;
        ext_addr  = go_ext ? addr : '0;
        ext_dout  = ext_oe ? wdata : '0;
        unique case (target)
            TGT_REG: rdata = reg_rdata;
            TGT_ROM: rdata = rom_rdata;
            default: rdata = ext_din;
        endcase
    end
endmodule

// File: rtl/wait_bus_ctrl.sv
module wait_bus_ctrl
    import wbc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int WAIT_W    = 3,
    parameter int REG_LIMIT = 448
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req,
    input  logic              core_we,
    input  logic              core_code,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    output logic [DATA_W-1:0] core_rdata,
    output logic              core_ready,
    input  logic [WAIT_W-1:0] code_waits,
    input  logic [WAIT_W-1:0] data_waits,
    input  logic              rom_nowait,
    input  logic              rom_lo_en_n,
    input  logic              rom_hi_en_n,
    output logic              reg_sel,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              rom_sel,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [DATA_W-1:0] ext_dout,
    input  logic [DATA_W-1:0] ext_din,
    output logic              ext_oe,
    output logic              ext_code_rd_n,
    output logic              ext_code_wr_n,
    output logic              ext_data_rd_n,
    output logic              ext_data_wr_n
);
    localparam int MAX_WAIT = (1 << WAIT_W) - 1;
    localparam int STALL_W  = WAIT_W + 1;

    target_e           target;
    logic [WAIT_W-1:0] waits;

    wbc_decode #(.ADDR_W(ADDR_W), .WAIT_W(WAIT_W), .REG_LIMIT(REG_LIMIT)) u_dec (
        .code(core_code), .we(core_we), .addr(core_addr),
        .lo_en_n(rom_lo_en_n), .hi_en_n(rom_hi_en_n), .rom_nowait(rom_nowait),
        .code_waits(code_waits), .data_waits(data_waits),
        .target(target), .waits(waits)
    );

    wbc_seq #(.WAIT_W(WAIT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req(core_req), .waits(waits), .ready(core_ready)
    );

    wbc_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
        .req(core_req), .we(core_we), .code(core_code), .target(target),
        .addr(core_addr), .wdata(core_wdata), .ext_din(ext_din),
        .reg_rdata(reg_rdata), .rom_rdata(rom_rdata), .rdata(core_rdata),
        .reg_sel(reg_sel), .rom_sel(rom_sel), .ext_addr(ext_addr),
        .ext_dout(ext_dout), .ext_oe(ext_oe),
        .code_rd_n(ext_code_rd_n), .code_wr_n(ext_code_wr_n),
        .data_rd_n(ext_data_rd_n), .data_wr_n(ext_data_wr_n)
    );

    // Stall-length watch for the bound on extra clocks
    logic [STALL_W-1:0] stall_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stall_cnt <= '0;
        else if (!core_req || core_ready)
            stall_cnt <= '0;
        else
            stall_cnt <= stall_cnt + 1'b1;
    end

    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !core_req |-> (ext_code_rd_n && ext_code_wr_n && ext_data_rd_n && ext_data_wr_n
                       && !ext_oe && !core_ready));
    p_reg_nowait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> core_ready);
    p_stall_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
        32'(stall_cnt) <= MAX_WAIT);
    p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!ext_code_rd_n, !ext_code_wr_n, !ext_data_rd_n, !ext_data_wr_n}));
    p_oe_in_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_oe |-> (!ext_code_wr_n || !ext_data_wr_n));
endmodule

// File: tb/wait_bus_ctrl_tb_top.sv
module wait_bus_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_req = 1'b0, core_we = 1'b0, core_code = 1'b0;
    logic [15:0] core_addr = '0;
    logic [7:0]  core_wdata = '0;
    logic [7:0]  core_rdata;
    logic        core_ready;
    logic [2:0]  code_waits = 3'd1, data_waits = 3'd3;
    logic        rom_nowait = 1'b0, rom_lo_en_n = 1'b0, rom_hi_en_n = 1'b1;
    logic        reg_sel, rom_sel, ext_oe;
    logic [7:0]  reg_rdata, rom_rdata, ext_din, ext_dout;
    logic [15:0] ext_addr;
    logic        crd_n, cwr_n, drd_n, dwr_n;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    assign reg_rdata = core_addr[7:0] ^ 8'h3C;
    assign rom_rdata = core_addr[7:0] ^ 8'hC3;
    assign ext_din   = core_addr[7:0] ^ 8'h5A;

    wait_bus_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_we(core_we),
        .core_code(core_code), .core_addr(core_addr), .core_wdata(core_wdata),
        .core_rdata(core_rdata), .core_ready(core_ready),
        .code_waits(code_waits), .data_waits(data_waits), .rom_nowait(rom_nowait),
        .rom_lo_en_n(rom_lo_en_n), .rom_hi_en_n(rom_hi_en_n),
        .reg_sel(reg_sel), .reg_rdata(reg_rdata), .rom_sel(rom_sel), .rom_rdata(rom_rdata),
        .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_din(ext_din), .ext_oe(ext_oe),
        .ext_code_rd_n(crd_n), .ext_code_wr_n(cwr_n),
        .ext_data_rd_n(drd_n), .ext_data_wr_n(dwr_n)
    );

    // target: 0 register RAM, 1 internal ROM, 2 external
    typedef struct {
        int         cycles;
        int         tgt;
        logic [3:0] strobes;  // {code_rd, code_wr, data_rd, data_wr} seen low
        logic       rd;
        logic [7:0] rdata;
        string      tag;
    } exp_t;

    exp_t q[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input int got, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: got %0h exp %0h", tag, what, got, exp);
        end
    endtask

    task automatic access(input bit code, input bit we, input logic [15:0] a,
                          input logic [7:0] wd, input int cyc, input int tgt,
                          input logic [3:0] stb, input string tag);
        exp_t e;
        logic [7:0] x;
        x = (tgt == 0) ? 8'h3C : (tgt == 1) ? 8'hC3 : 8'h5A;
        e.cycles = cyc; e.tgt = tgt; e.strobes = stb; e.rd = !we;
        e.rdata = a[7:0] ^ x; e.tag = tag;
        q.push_back(e);
        @(posedge clk); #1;
        core_req = 1'b1; core_code = code; core_we = we; core_addr = a; core_wdata = wd;
        do @(negedge clk); while (!core_ready);
        @(posedge clk); #1;
        core_req = 1'b0;
    endtask

    // Monitor: samples mid-cycle and compares with the scoreboard queue.
    initial begin
        int cyc = 0;
        logic [3:0] seen = '0;
        logic regs = 1'b0, roms = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && core_req) begin
                cyc++;
                seen |= {!crd_n, !cwr_n, !drd_n, !dwr_n};
                regs |= reg_sel; roms |= rom_sel;
                if (ext_oe && ext_dout != core_wdata)
                    check(0, "R8", "write data", int'(ext_dout), int'(core_wdata));
                if (ext_oe != (!cwr_n || !dwr_n))
                    check(0, "R8", "drive enable", int'(ext_oe), int'(!cwr_n || !dwr_n));
                if ((!crd_n || !cwr_n || !drd_n || !dwr_n) && ext_addr != core_addr)
                    check(0, "R9", "ext address", int'(ext_addr), int'(core_addr));
                if (core_ready) begin
                    exp_t e;
                    if (q.size() == 0) begin
                        check(0, "R5", "unexpected completion", 0, 1);
                    end else begin
                        e = q.pop_front();
                        check(cyc == e.cycles, e.tag, "cycles", cyc, e.cycles);
                        check(seen == e.strobes, e.tag, "strobes", int'(seen), int'(e.strobes));
                        check(regs == (e.tgt == 0), e.tag, "reg_sel", int'(regs), int'(e.tgt == 0));
                        check(roms == (e.tgt == 1), e.tag, "rom_sel", int'(roms), int'(e.tgt == 1));
                        if (e.rd)
                            check(core_rdata == e.rdata, e.tag, "rdata", int'(core_rdata), int'(e.rdata));
                    end
                    cyc = 0; seen = '0; regs = 1'b0; roms = 1'b0;
                end
            end
        end
    end

    initial begin
        #1500000;
        check(0, "R5", "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(crd_n && cwr_n && drd_n && dwr_n, "R1", "strobes in reset",
              int'({crd_n, cwr_n, drd_n, dwr_n}), 15);
        check(!ext_oe && !core_ready, "R1", "oe/ready in reset", int'({ext_oe, core_ready}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(crd_n && cwr_n && drd_n && dwr_n && !core_ready, "R1", "idle quiet",
              int'({crd_n, cwr_n, drd_n, dwr_n, core_ready}), 30);

        // Phase A: code 1, data 3, lower half enabled
        access(0, 0, 16'h0010, 8'h00, 1, 0, 4'b0000, "R2");
        access(0, 1, 16'h01BF, 8'hA5, 1, 0, 4'b0000, "R2");
        access(0, 0, 16'h01C0, 8'h00, 4, 2, 4'b0010, "R10");
        access(0, 1, 16'h2000, 8'h77, 4, 2, 4'b0001, "R6");
        access(1, 0, 16'h1234, 8'h00, 2, 1, 4'b0000, "R3");
        access(1, 0, 16'h8001, 8'h00, 2, 2, 4'b1000, "R4");
        access(1, 1, 16'h4000, 8'h9C, 2, 2, 4'b0100, "R7");

        // Phase B: code 5, data 2 (raised to 5), upper half enabled, ROM skips waits
        @(posedge clk); #1;
        code_waits = 3'd5; data_waits = 3'd2; rom_nowait = 1'b1;
        rom_lo_en_n = 1'b1; rom_hi_en_n = 1'b0;
        access(0, 0, 16'h3000, 8'h00, 6, 2, 4'b0010, "R6");
        access(1, 0, 16'h9000, 8'h00, 1, 1, 4'b0000, "R3");
        access(1, 0, 16'h0100, 8'h00, 6, 2, 4'b1000, "R5");
        access(0, 0, 16'h0005, 8'h00, 1, 0, 4'b0000, "R2");

        // Phase C: zero waits, then the maximum
        @(posedge clk); #1;
        code_waits = 3'd0; data_waits = 3'd0; rom_nowait = 1'b0;
        access(0, 0, 16'hFFFF, 8'h00, 1, 2, 4'b0010, "R10");
        access(1, 1, 16'hC000, 8'h3E, 1, 2, 4'b0100, "R8");
        @(posedge clk); #1;
        code_waits = 3'd7; data_waits = 3'd7;
        access(0, 1, 16'h5555, 8'h12, 8, 2, 4'b0001, "R6");
        access(1, 0, 16'hA0A0, 8'h00, 8, 1, 4'b0000, "R3");

        repeat (3) @(negedge clk);
        check(q.size() == 0, "R5", "pending items", q.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule